// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Translator

This block turns a single-word read on a simple internal bus into a complete read transaction on a serial flash port. A 32-bit setup word picks the read opcode, how many address bytes follow it, how many dummy clock slots come before the data, and whether the data comes back on one, two or four lanes. A separate switch input decides whether the translator owns the serial pins at all. When it does not, or when the setup word is all zeros, a read is refused at once and the pins stay quiet.

For an accepted read the block drives chip select to its active level and shifts out the opcode, then the low bytes of the bus offset, on one lane, most significant bit first. It then runs the dummy slots and collects 32 data bits on the selected lanes. It releases chip select and returns the word with a one-cycle ready pulse. The serial clock uses the same divider, clock polarity, clock phase and chip-select polarity inputs as the register-driven command engine that shares these pins.

States: `ST_IDLE` waits for a request. On `rd_req` it moves to `ST_REJECT` when the switch is 0 or the setup word is zero, and to `ST_CMD` otherwise. `ST_CMD` (8 slots) moves to `ST_ADDR` (8×address-byte slots). `ST_ADDR` moves to `ST_DUMMY` when the dummy count is non-zero, and to `ST_DATA` when it is zero. `ST_DUMMY` moves to `ST_DATA`, which lasts 32/lanes slots. `ST_DATA` moves to `ST_FINISH`. `ST_FINISH` and `ST_REJECT` each last one cycle and return to `ST_IDLE`.

Top module: `mmflash_xlate`

## Requirements
- R1: Out of reset, and whenever no transaction is in progress, `cs_o` sits at `~cs_act_high`, `sclk_o` sits at `cpol`, and `rd_ready` is 0.
- R2: A `rd_req` seen in idle while `mm_sel` is 0 gives `rd_ready`=1 with `rd_err`=1 and `rd_data`=0 in the next cycle. `sclk_o` and `cs_o` do not toggle.
- R3: A `rd_req` seen in idle while `setup_word` is all zeros is refused in the same way as in R2.
- R4: The opcode in `setup_word[7:0]` is sent first, MSB first, one bit per SCLK slot on `mosi_o`.
- R5: `setup_word[9:8]` holds the number of address bytes minus one (1 to 4 bytes). The address bytes are the low bytes of `rd_addr`, sent most significant byte first and MSB first on `mosi_o`.
- R6: The number of dummy slots between address and data is 8×`setup_word[11:10]` + `setup_word[28:24]`. The total number of SCLK sample edges is 8 + 8×address bytes + dummy slots + 32/lanes.
- R7: `setup_word[13:12]` selects the data lanes. With 0 or 2, one bit per slot is taken from `io_i[1]`. With 1, two bits per slot are taken as {`io_i[1]`,`io_i[0]`}. With 3, four bits per slot are taken from `io_i[3:0]`, with `io_i[3]` the most significant.
- R8: The first received byte lands in `rd_data[7:0]`, the fourth in `rd_data[31:24]`. Each byte is received MSB first.
- R9: Each SCLK half period lasts `clk_div`+1 clock cycles. SCLK idles at `cpol`. With `cpol`^`cpha`=0 data is sampled on the rising edge, otherwise on the falling edge. `rd_ready` rises slots×2×(`clk_div`+1)+1 cycles after the request is sampled.
- R10: `cs_o` is at `cs_act_high` for the whole transaction and back at the inactive level when `rd_ready` pulses. `rd_ready` lasts exactly one cycle, with `rd_err`=0 for a completed read.
- R11: The field `setup_word[23:16]` has no effect on a read.
- R12: A `rd_req` that arrives while a transaction is in progress is ignored. No second transaction and no second ready pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mm_sel | input | 1 | 1: translator owns the serial pins |
| setup_word | input | 32 | Read setup word, fields per R4 to R7 |
| clk_div | input | DIV_W | SCLK half-period length minus one |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | Clock phase |
| cs_act_high | input | 1 | Active level of chip select |
| rd_req | input | 1 | One-cycle read request pulse |
| rd_addr | input | ADDR_W | Byte offset within the window |
| rd_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Returned word |
| rd_err | output | 1 | Read refused |
| sclk_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| mosi_o | output | 1 | Opcode and address lane |
| io_i | input | 4 | Data lanes from the flash |

## Verification
A wrong slot count or a stuck phase counter in the state machine shows up on the serial port during the same transaction. The number of sample edges is wrong, and `rd_ready` arrives on the wrong cycle. Wrong lane selection or byte order corrupts `rd_data` on the first read in that mode. A bad shift-register load shows up as a wrong opcode or address on `mosi_o` within the first 8 to 40 sample edges. A faulty refusal path shows up as SCLK or chip-select activity, or a missing error, one cycle after the request.

// File: rtl/mmx_pkg.sv
`timescale 1ns/1ps
package mmx_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_FINISH,
        ST_REJECT
    } mmx_state_t;

    typedef enum logic [1:0] {
        LANE_X1,
        LANE_X2,
        LANE_X4
    } mmx_lane_t;

    typedef struct packed {
        logic [7:0] opcode;
        logic [2:0] addr_bytes;
        logic [5:0] dummy_slots;
        mmx_lane_t  lanes;
    } mmx_cfg_t;

    // Field positions are fixed by the software that programs the word.
    function automatic mmx_cfg_t mmx_decode(input logic [31:0] w);
        mmx_cfg_t c;
        c.opcode      = w[7:0];
        c.addr_bytes  = {1'b0, w[9:8]} + 3'd1;
        c.dummy_slots = {1'b0, w[11:10], 3'b000} + {1'b0, w[28:24]};
        unique case (w[13:12])
            2'd1:    c.lanes = LANE_X2;
            2'd3:    c.lanes = LANE_X4;
            default: c.lanes = LANE_X1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mmx_sclk_gen.sv
`timescale 1ns/1ps
module mmx_sclk_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half,
    output logic             mid_tick,
    output logic             end_tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_lim;

    assign at_lim   = (cnt_q == div);
    assign mid_tick = run && !half && at_lim;
    assign end_tick = run &&  half && at_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            half  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            half  <= 1'b0;
        end else if (at_lim) begin
            cnt_q <= '0;
            half  <= ~half;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the second half of a slot always follows a mid tick
    a_r9_half_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_tick && run) |=> (half || !run));

endmodule

// File: rtl/mmx_tx_shift.sv
`timescale 1ns/1ps
module mmx_tx_shift #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [7:0]        opcode,
    input  logic [2:0]        addr_bytes,
    input  logic [ADDR_W-1:0] addr,
    output logic              bit_o
);

    localparam int SH_W = 8 + 32;

    logic [SH_W-1:0] sh_q;
    logic [31:0]     addr32;
    logic [31:0]     aligned;
    logic [2:0]      unused_bytes;

    assign addr32       = 32'(addr);
    assign unused_bytes = 3'd4 - addr_bytes;
    assign aligned      = addr32 << {unused_bytes, 3'b000};
    assign bit_o        = sh_q[SH_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= {opcode, aligned};
        else if (shift) sh_q <= {sh_q[SH_W-2:0], 1'b0};
    end

endmodule

// File: rtl/mmx_rx_cap.sv
`timescale 1ns/1ps
module mmx_rx_cap
    import mmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  mmx_lane_t         lanes,
    input  logic [3:0]        io_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clear) begin
            sh_q <= '0;
        end else if (capture) begin
            unique case (lanes)
                LANE_X2: sh_q <= {sh_q[WORD_W-3:0], io_i[1:0]};
                LANE_X4: sh_q <= {sh_q[WORD_W-5:0], io_i};
                default: sh_q <= {sh_q[WORD_W-2:0], io_i[1]};
            endcase
        end
    end

    // First byte on the wire ends up in the lowest byte lane.
    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign word_o[8*b +: 8] = sh_q[WORD_W-8-8*b +: 8];
    end

endmodule

// File: rtl/mmflash_xlate.sv
`timescale 1ns/1ps
module mmflash_xlate
    import mmx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mm_sel,
    input  logic [31:0]       setup_word,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              cs_act_high,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [31:0]       rd_data,
    output logic              rd_err,
    output logic              sclk_o,
    output logic              cs_o,
    output logic              mosi_o,
    input  logic [3:0]        io_i
);

    localparam int SLOT_W = 6;

    mmx_state_t        state_q, state_d;
    logic [SLOT_W-1:0] slots_q, slots_d;
    mmx_cfg_t          cfg_q;
    logic              busy, accept, refuse;
    logic              half, mid_tick, end_tick;
    logic              tx_bit;
    logic [WORD_W-1:0] rx_word;
    logic [SLOT_W-1:0] data_last;
    logic              shifting;

    assign busy     = (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                      (state_q == ST_DUMMY) || (state_q == ST_DATA);
    assign shifting = (state_q == ST_CMD) || (state_q == ST_ADDR);
    assign refuse   = !mm_sel || (setup_word == 32'd0);
    assign accept   = (state_q == ST_IDLE) && rd_req && !refuse;

    always_comb begin
        unique case (cfg_q.lanes)
            LANE_X2: data_last = SLOT_W'(WORD_W/2 - 1);
            LANE_X4: data_last = SLOT_W'(WORD_W/4 - 1);
            default: data_last = SLOT_W'(WORD_W - 1);
        endcase
    end

    mmx_sclk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(clk_div),
        .half(half), .mid_tick(mid_tick), .end_tick(end_tick)
    );

    mmx_tx_shift #(.ADDR_W(ADDR_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .shift(end_tick && shifting),
        .opcode(setup_word[7:0]), .addr_bytes({1'b0, setup_word[9:8]} + 3'd1),
        .addr(rd_addr), .bit_o(tx_bit)
    );

    mmx_rx_cap u_rx (
        .clk(clk), .rst_n(rst_n), .clear(accept),
        .capture(mid_tick && (state_q == ST_DATA)),
        .lanes(cfg_q.lanes), .io_i(io_i), .word_o(rx_word)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        slots_d = slots_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_req) begin
                    if (refuse) begin
                        state_d = ST_REJECT;
                    end else begin
                        state_d = ST_CMD;
                        slots_d = SLOT_W'(7);
                    end
                end
            end
            ST_CMD: begin
                if (end_tick) begin
                    if (slots_q == '0) begin
                        state_d = ST_ADDR;
                        slots_d = {cfg_q.addr_bytes, 3'b000} - 1'b1;
                    end else begin
                        slots_d = slots_q - 1'b1;
                    end
                end
            end
            ST_ADDR: begin
                if (end_tick) begin
                    if (slots_q != '0) begin
                        slots_d = slots_q - 1'b1;
                    end else if (cfg_q.dummy_slots != '0) begin
                        state_d = ST_DUMMY;
                        slots_d = cfg_q.dummy_slots - 1'b1;
                    end else begin
                        state_d = ST_DATA;
                        slots_d = data_last;
                    end
                end
            end
            ST_DUMMY: begin
                if (end_tick) begin
                    if (slots_q == '0) begin
                        state_d = ST_DATA;
                        slots_d = data_last;
                    end else begin
                        slots_d = slots_q - 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (end_tick) begin
                    if (slots_q == '0) state_d = ST_FINISH;
                    else               slots_d = slots_q - 1'b1;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slots_q <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            slots_q <= slots_d;
            if (accept) cfg_q <= mmx_decode(setup_word);
        end
    end

    // Outputs
    always_comb begin
        sclk_o   = busy ? (cpol ^ cpha ^ half) : cpol;
        cs_o     = busy ? cs_act_high : ~cs_act_high;
        mosi_o   = shifting ? tx_bit : 1'b0;
        rd_ready = (state_q == ST_FINISH) || (state_q == ST_REJECT);
        rd_err   = (state_q == ST_REJECT);
        rd_data  = (state_q == ST_FINISH) ? rx_word : '0;
    end

    a_r2_refuse_unowned: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rd_req && !mm_sel) |=> (rd_ready && rd_err && rd_data == '0));

    a_r3_refuse_zero_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rd_req && setup_word == 32'd0) |=> (rd_ready && rd_err));

    a_r10_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);

    a_r10_cs_released: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (cs_o != cs_act_high));

    a_r6_dummy_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DUMMY) |-> (cfg_q.dummy_slots != '0));

endmodule

// File: tb/mmflash_xlate_tb_top.sv
`timescale 1ns/1ps
module mmflash_xlate_tb_top;

    localparam int ADDR_W = 24;
    localparam int DIV_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mm_sel = 1'b0;
    logic [31:0]       setup_word = '0;
    logic [DIV_W-1:0]  clk_div = '0;
    logic              cpol = 1'b0, cpha = 1'b0, cs_act_high = 1'b0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_ready, rd_err, sclk_o, cs_o, mosi_o;
    logic [31:0]       rd_data;
    logic [3:0]        io_drv = 4'h0;

    int n_total = 0, n_fail = 0;
    bit done = 1'b0;

    // flash model state (written only by the model)
    int          edges = 0;
    logic [39:0] cap = '0;
    int          sclk_tog = 0, cs_tog = 0;
    // access description (written only by the stimulus)
    int          cur_lanes = 1, pre_bits = 8, hdr_bits = 16;
    logic [31:0] pat = '0;

    always #2 clk = ~clk;

    mmflash_xlate #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mm_sel(mm_sel), .setup_word(setup_word),
        .clk_div(clk_div), .cpol(cpol), .cpha(cpha), .cs_act_high(cs_act_high),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_err(rd_err), .sclk_o(sclk_o), .cs_o(cs_o), .mosi_o(mosi_o), .io_i(io_drv)
    );

    always @(cs_o) begin
        cs_tog++;
        if (cs_o == cs_act_high) begin
            edges = 0;
            cap   = '0;
            io_drv <= #1 4'b1010;
        end
    end

    always @(sclk_o) begin
        logic [31:0] s;
        int k;
        sclk_tog++;
        if (cs_o == cs_act_high && sclk_o == ~(cpol ^ cpha)) begin
            if (edges < hdr_bits) cap = {cap[38:0], mosi_o};
            edges++;
            if (edges >= pre_bits) begin
                k = edges - pre_bits;
                if (k < 32 / cur_lanes) begin
                    s = pat >> (32 - cur_lanes * (k + 1));
                    case (cur_lanes)
                        1:       io_drv <= #1 {2'b00, s[0], 1'b0};
                        2:       io_drv <= #1 {2'b00, s[1:0]};
                        default: io_drv <= #1 s[3:0];
                    endcase
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [31:0] sw, input logic [ADDR_W-1:0] a, input bit poke);
        int ab, dm, ln, slots, cyc, exp_cyc, t0;
        longint exp_hdr;
        logic [31:0] exp_data;
        ab = int'(sw[9:8]) + 1;
        dm = 8 * int'(sw[11:10]) + int'(sw[28:24]);
        ln = (sw[13:12] == 2'd1) ? 2 : (sw[13:12] == 2'd3) ? 4 : 1;
        slots = 8 + 8 * ab + dm + 32 / ln;
        exp_cyc = slots * 2 * (int'(clk_div) + 1) + 1;
        setup_word = sw;
        cur_lanes = ln;
        hdr_bits = 8 + 8 * ab;
        pre_bits = 8 + 8 * ab + dm;
        pat = {8'(a), 8'(a >> 8), 8'(a >> 16), 8'(a ^ 24'h3C)} ^ 32'h9E3779B1;
        exp_data = {pat[7:0], pat[15:8], pat[23:16], pat[31:24]};
        exp_hdr = (longint'(sw[7:0]) << (8 * ab)) | (longint'(a) & ((64'd1 << (8 * ab)) - 1));
        @(negedge clk);
        rd_req = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        cyc = 1;
        while (!rd_ready && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            rd_req = (poke && cyc == 3);
        end
        rd_req = 1'b0;
        chk(cyc == exp_cyc, "R9 ready cycle", cyc, exp_cyc);
        chk(rd_err == 1'b0 && rd_data == exp_data, "R7 R8 R11 data", rd_data, exp_data);
        chk(longint'(cap) == exp_hdr, "R4 R5 opcode/address", cap, exp_hdr);
        chk(edges == slots, "R6 sample edges", edges, slots);
        chk(cs_o == ~cs_act_high, "R10 cs released", cs_o, ~cs_act_high);
        @(negedge clk);
        chk(rd_ready == 1'b0, "R10 ready one cycle", rd_ready, 0);
        if (poke) begin
            t0 = cs_tog;
            repeat (6) begin
                @(negedge clk);
                chk(rd_ready == 1'b0, "R12 no second ready", rd_ready, 0);
            end
            chk(cs_tog == t0, "R12 no second transaction", cs_tog - t0, 0);
        end
    endtask

    task automatic do_refuse(input logic [31:0] sw, input bit sel, input string req);
        int t_s, t_c;
        setup_word = sw;
        mm_sel = sel;
        @(negedge clk);
        t_s = sclk_tog;
        t_c = cs_tog;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_ready && rd_err && rd_data == 32'd0, req, {rd_ready, rd_err, rd_data}, 34'h3_0000_0000);
        @(negedge clk);
        chk(rd_ready == 1'b0, req, rd_ready, 0);
        chk(sclk_tog == t_s && cs_tog == t_c, req, sclk_tog - t_s + cs_tog - t_c, 0);
        mm_sel = 1'b1;
    endtask

    initial begin
        int it;
        logic [4:0] dbits;
        logic [1:0] db;
        it = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cs_o == ~cs_act_high && sclk_o == cpol && !rd_ready, "R1 reset outputs",
            {cs_o, sclk_o, rd_ready}, {~cs_act_high, cpol, 1'b0});
        rst_n = 1'b1;
        mm_sel = 1'b1;
        @(negedge clk);
        do_refuse(32'h0012_0003, 1'b0, "R2 switch off refusal");
        do_refuse(32'h0000_0000, 1'b1, "R3 zero setup refusal");
        for (int mode = 0; mode < 4; mode++) begin
            for (int dv = 0; dv < 2; dv++) begin
                cpol = mode[1];
                cpha = mode[0];
                cs_act_high = (mode == 3);
                clk_div = DIV_W'(dv);
                @(negedge clk);
                chk(cs_o == ~cs_act_high && sclk_o == cpol, "R1 idle levels",
                    {cs_o, sclk_o}, {~cs_act_high, cpol});
                for (int rt = 0; rt < 4; rt++) begin
                    for (int ab = 0; ab < 4; ab++) begin
                        for (int dz = 0; dz < 3; dz++) begin
                            db    = (dz == 1) ? 2'd1 : 2'd0;
                            dbits = (dz == 2) ? 5'd5 : 5'd0;
                            do_read({3'b000, dbits, 8'(8'h5A ^ it), 2'b00, 2'(rt), db, 2'(ab),
                                     8'(8'h0B ^ (rt * 16 + ab))},
                                    24'hA5C3E1 ^ (24'(it) * 24'h010203), (it % 7) == 3);
                            it++;
                        end
                    end
                end
            end
        end
        do_refuse(32'h0012_0003, 1'b0, "R2 switch off after use");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total + 1);
            $finish;
        end
    end

endmodule